// File: doc/BRIEF.md
# Overlay Colour Mixer

This block blends a fixed overlay colour into a stream of YCbCr pixels, one pixel per clock. Along with each pixel arrive a 3-bit overlay code and a 2-bit mix level. The code and the mix level are sampled on the same clock edge as the pixel they belong to. A code of zero means no overlay, and the pixel leaves the block unchanged. A nonzero code picks one of seven built-in colours, all at 75% amplitude.

For a nonzero code, the mix level sets how many quarters of the overlay colour go into the result: one, two, three or four. The incoming pixel supplies the remaining quarters. The weighted sum is rounded to the nearest integer and clamped to the nominal video range.

The block sits ahead of any vertical filtering or upsampling stage. Its output is a registered pixel with valid and blank flags. These flags are delayed by the same single cycle as the data.

Top module: `ovm_mixer`

## Requirements
- R1: While reset is asserted (rst_n low), out_valid, out_blank, out_y, out_cb and out_cr are all zero.
- R2: A valid pixel with ovl_code 0 appears unchanged on out_y/out_cb/out_cr one cycle later, whatever mix_lvl is.
- R3: ovl_code values 1 to 7 select these colours as (Y,Cb,Cr): 1=(180,128,128) white, 2=(162,44,142) yellow, 3=(131,156,44) cyan, 4=(112,72,58) green, 5=(84,184,198) magenta, 6=(65,100,212) red, 7=(35,212,114) blue. With mix_lvl 3, the output equals the selected colour exactly.
- R4: For a nonzero code, mix_lvl m gives an overlay weight w=m+1 quarters, so mix_lvl 0,1,2,3 mean 25%, 50%, 75% and 100%. Each channel becomes floor((ovl*w + pix*(4-w) + 2)/4).
- R5: Blended results are clamped to 16..235 for Y and to 16..240 for Cb and Cr. Pass-through pixels (code 0) are not clamped.
- R6: out_valid and out_blank equal in_valid and in_blank of the previous clock. A blanked pixel is processed like any other.
- R7: After a cycle with in_valid low, out_y/out_cb/out_cr keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_blank | input | 1 | Blanking flag travelling with the pixel |
| in_y | input | DATA_W | Input luma |
| in_cb | input | DATA_W | Input blue difference |
| in_cr | input | DATA_W | Input red difference |
| ovl_code | input | 3 | Overlay colour select, 0 = none |
| mix_lvl | input | 2 | Overlay weight select |
| out_valid | output | 1 | Output pixel qualifier |
| out_blank | output | 1 | Delayed blanking flag |
| out_y | output | DATA_W | Output luma |
| out_cb | output | DATA_W | Output blue difference |
| out_cr | output | DATA_W | Output red difference |

## Verification
The assertions check four things on every cycle: the one-cycle alignment of the valid and blank flags, the pass-through for code zero, the holding of data while the input is idle, and the clamp ranges on blended pixels. They also check that a full mix level reproduces the palette colour. Only the bench scenarios can show that the arithmetic of the partial weights is right, including the rounding at each of the three fractional levels. The same holds for the exact palette value of every code and for the clamping of out-of-range input pixels. The bench sweeps every code against every mix level and a set of extreme and mid-range pixel values.

// File: rtl/ovm_pkg.sv
package ovm_pkg;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } ycc8_t;

    // Seven 75%-amplitude colours, 8-bit nominal-range values.
    function automatic ycc8_t palette8(input logic [2:0] code);
        ycc8_t c;
        unique case (code)
            3'd1:    c = '{y: 8'd180, cb: 8'd128, cr: 8'd128};
            3'd2:    c = '{y: 8'd162, cb: 8'd44,  cr: 8'd142};
            3'd3:    c = '{y: 8'd131, cb: 8'd156, cr: 8'd44};
            3'd4:    c = '{y: 8'd112, cb: 8'd72,  cr: 8'd58};
            3'd5:    c = '{y: 8'd84,  cb: 8'd184, cr: 8'd198};
            3'd6:    c = '{y: 8'd65,  cb: 8'd100, cr: 8'd212};
            3'd7:    c = '{y: 8'd35,  cb: 8'd212, cr: 8'd114};
            default: c = '{y: 8'd16,  cb: 8'd128, cr: 8'd128};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/ovm_palette.sv
module ovm_palette #(
    parameter int DATA_W = 8
) (
    input  logic [2:0]        code,
    output logic [DATA_W-1:0] col_y,
    output logic [DATA_W-1:0] col_cb,
    output logic [DATA_W-1:0] col_cr
);
    localparam int LSH = DATA_W - 8;

    ovm_pkg::ycc8_t base;

    always_comb begin
        base   = ovm_pkg::palette8(code);
        col_y  = DATA_W'(base.y)  << LSH;
        col_cb = DATA_W'(base.cb) << LSH;
        col_cr = DATA_W'(base.cr) << LSH;
    end
endmodule

// File: rtl/ovm_blend_lane.sv
module ovm_blend_lane #(
    parameter int          DATA_W = 8,
    parameter logic [15:0] LO     = 16'd16,
    parameter logic [15:0] HI     = 16'd235
) (
    input  logic [DATA_W-1:0] pix,
    input  logic [DATA_W-1:0] ovl,
    input  logic [1:0]        mix,
    output logic [DATA_W-1:0] res
);
    localparam int SW = DATA_W + 3;
    localparam logic [DATA_W:0] LO_X = (DATA_W+1)'(LO);
    localparam logic [DATA_W:0] HI_X = (DATA_W+1)'(HI);

    logic [2:0]      w_ovl;
    logic [2:0]      w_pix;
    logic [SW-1:0]   acc;
    logic [DATA_W:0] avg;

    always_comb begin
        w_ovl = {1'b0, mix} + 3'd1;
        w_pix = 3'd4 - w_ovl;
        acc   = SW'(ovl) * SW'(w_ovl) + SW'(pix) * SW'(w_pix) + SW'(2);
        avg   = acc[SW-1:2];
        if (avg < LO_X)
            res = LO_X[DATA_W-1:0];
        else if (avg > HI_X)
            res = HI_X[DATA_W-1:0];
        else
            res = avg[DATA_W-1:0];
    end
endmodule

// File: rtl/ovm_mixer.sv
module ovm_mixer #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_blank,
    input  logic [DATA_W-1:0] in_y,
    input  logic [DATA_W-1:0] in_cb,
    input  logic [DATA_W-1:0] in_cr,
    input  logic [2:0]        ovl_code,
    input  logic [1:0]        mix_lvl,
    output logic              out_valid,
    output logic              out_blank,
    output logic [DATA_W-1:0] out_y,
    output logic [DATA_W-1:0] out_cb,
    output logic [DATA_W-1:0] out_cr
);
    localparam int          LANES = 3;
    localparam int          LSH   = DATA_W - 8;
    localparam logic [15:0] Y_LO  = 16'(16)  << LSH;
    localparam logic [15:0] Y_HI  = 16'(235) << LSH;
    localparam logic [15:0] C_LO  = 16'(16)  << LSH;
    localparam logic [15:0] C_HI  = 16'(240) << LSH;

    logic [DATA_W-1:0] col_y, col_cb, col_cr;
    logic [DATA_W-1:0] pix_v [LANES];
    logic [DATA_W-1:0] ovl_v [LANES];
    logic [DATA_W-1:0] mix_v [LANES];
    logic [DATA_W-1:0] nxt   [LANES];
    logic              use_ovl;

    ovm_palette #(.DATA_W(DATA_W)) pal_i (
        .code   (ovl_code),
        .col_y  (col_y),
        .col_cb (col_cb),
        .col_cr (col_cr)
    );

    assign pix_v[0] = in_y;
    assign pix_v[1] = in_cb;
    assign pix_v[2] = in_cr;
    assign ovl_v[0] = col_y;
    assign ovl_v[1] = col_cb;
    assign ovl_v[2] = col_cr;
    assign use_ovl  = (ovl_code != 3'd0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [15:0] LO_G = (g == 0) ? Y_LO : C_LO;
        localparam logic [15:0] HI_G = (g == 0) ? Y_HI : C_HI;
        ovm_blend_lane #(.DATA_W(DATA_W), .LO(LO_G), .HI(HI_G)) lane_i (
            .pix (pix_v[g]),
            .ovl (ovl_v[g]),
            .mix (mix_lvl),
            .res (mix_v[g])
        );
        assign nxt[g] = use_ovl ? mix_v[g] : pix_v[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_blank <= 1'b0;
            out_y     <= '0;
            out_cb    <= '0;
            out_cr    <= '0;
        end else begin
            out_valid <= in_valid;
            out_blank <= in_blank;
            if (in_valid) begin
                out_y  <= nxt[0];
                out_cb <= nxt[1];
                out_cr <= nxt[2];
            end
        end
    end

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid) || !$past(rst_n)); // R6
    AST_BLANK_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        in_blank |=> out_blank); // R6
    AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovl_code == 3'd0) |=>
        (out_y == $past(in_y) && out_cb == $past(in_cb) && out_cr == $past(in_cr))); // R2
    AST_FULL_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovl_code != 3'd0 && mix_lvl == 2'd3) |=>
        (out_y == $past(col_y) && out_cb == $past(col_cb) && out_cr == $past(col_cr))); // R3
    AST_CLAMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ovl_code != 3'd0) |=>
        (16'(out_y) >= Y_LO && 16'(out_y) <= Y_HI &&
         16'(out_cb) >= C_LO && 16'(out_cb) <= C_HI &&
         16'(out_cr) >= C_LO && 16'(out_cr) <= C_HI)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_y) && $stable(out_cb) && $stable(out_cr))); // R7
endmodule

// File: tb/ovm_mixer_tb.sv
module ovm_mixer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0, in_blank = 1'b0;
    logic [7:0] in_y = '0, in_cb = '0, in_cr = '0;
    logic [2:0] ovl_code = '0;
    logic [1:0] mix_lvl = '0;
    logic       out_valid, out_blank;
    logic [7:0] out_y, out_cb, out_cr;

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ovm_mixer #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_blank(in_blank),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .ovl_code(ovl_code), .mix_lvl(mix_lvl),
        .out_valid(out_valid), .out_blank(out_blank),
        .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    function automatic logic [23:0] ref_col(input int code);
        case (code)
            1: return {8'd180, 8'd128, 8'd128};
            2: return {8'd162, 8'd44,  8'd142};
            3: return {8'd131, 8'd156, 8'd44};
            4: return {8'd112, 8'd72,  8'd58};
            5: return {8'd84,  8'd184, 8'd198};
            6: return {8'd65,  8'd100, 8'd212};
            default: return {8'd35, 8'd212, 8'd114};
        endcase
    endfunction

    function automatic int blend(input int p, input int o, input int m, input int hi);
        int w = m + 1;
        int v = (o * w + p * (4 - w) + 2) / 4;
        if (v < 16) v = 16;
        if (v > hi) v = hi;
        return v;
    endfunction

    task automatic check(input string req, input logic [25:0] act, input logic [25:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drives one pixel, then checks the registered result just after the edge.
    task automatic send(input int y, input int cb, input int cr, input int code,
                        input int m, input bit blk, input string req);
        logic [23:0] c;
        int ey, ecb, ecr;
        @(negedge clk);
        in_valid = 1'b1; in_blank = blk;
        in_y = 8'(y); in_cb = 8'(cb); in_cr = 8'(cr);
        ovl_code = 3'(code); mix_lvl = 2'(m);
        if (code == 0) begin
            ey = y; ecb = cb; ecr = cr;
        end else begin
            c   = ref_col(code);
            ey  = blend(y,  c[23:16], m, 235);
            ecb = blend(cb, c[15:8],  m, 240);
            ecr = blend(cr, c[7:0],   m, 240);
        end
        @(posedge clk); #1;
        check(req, {out_valid, out_blank, out_y, out_cb, out_cr},
              {1'b1, blk, 8'(ey), 8'(ecb), 8'(ecr)});
    endtask

    initial begin : wdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int pv [6] = '{0, 16, 100, 128, 235, 255};
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", {out_valid, out_blank, out_y, out_cb, out_cr}, '0);
        @(negedge clk); rst_n = 1'b1;

        // R2: pass-through under every mix level, including out-of-range pixels
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 6; i++)
                send(pv[i], pv[(i + 2) % 6], pv[(i + 4) % 6], 0, m, 1'b0, "R2 pass");

        // R3: full mix gives palette colour for every code
        for (int c = 1; c < 8; c++)
            send(50, 200, 90, c, 3, 1'b0, "R3 palette");

        // R4/R5: every code x every mix x pixel set, clamping at extremes
        for (int c = 1; c < 8; c++)
            for (int m = 0; m < 4; m++)
                for (int i = 0; i < 6; i++) begin
                    send(pv[i], pv[5 - i], pv[(i + 3) % 6], c, m, 1'b0, "R4 blend");
                    send(255, 255, 255, c, m, 1'b0, "R5 clamp high");
                    send(0, 0, 0, c, m, 1'b0, "R5 clamp low");
                end

        // R6: blank flag travels with the pixel; processed normally
        send(100, 100, 100, 3, 1, 1'b1, "R6 blank");
        send(100, 100, 100, 0, 2, 1'b1, "R6 blank pass");
        send(100, 100, 100, 5, 0, 1'b0, "R6 unblank");

        // R7: idle cycle keeps data, out_valid drops
        send(77, 88, 99, 0, 0, 1'b0, "R7 prime");
        @(negedge clk);
        in_valid = 1'b0; in_blank = 1'b0;
        in_y = 8'd1; in_cb = 8'd2; in_cr = 8'd3; ovl_code = 3'd6; mix_lvl = 2'd3;
        @(posedge clk); #1;
        check("R7 hold", {out_valid, out_blank, out_y, out_cb, out_cr},
              {1'b0, 1'b0, 8'd77, 8'd88, 8'd99});
        @(posedge clk); #1;
        check("R7 hold2", {out_valid, out_blank, out_y, out_cb, out_cr},
              {1'b0, 1'b0, 8'd77, 8'd88, 8'd99});

        // R1: reset again mid-stream
        @(negedge clk); rst_n = 1'b0; #1;
        check("R1 reset async", {out_valid, out_blank, out_y, out_cb, out_cr}, '0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule